// File: doc/BRIEF.md
# Serial Register-Access Slave with Status Return and Burst Read

This block lets an external controller reach a bank of 32 byte-wide registers over a four-wire serial link. A transaction runs while chip select is held low. The first byte the controller sends is a command. It picks a read or a write, names a register, and can ask for an auto-incrementing burst read. The bytes after the command carry write data, or clock out read data. While the command byte is shifting in, the slave returns a status byte on MISO. That status byte is the interrupt flag vector as it stood just before chip select fell.

All four serial pins pass through synchronizers into the system clock domain, and clock edges are found there. The system clock must run at least 8 times faster than the serial clock. The register side is a plain strobe interface. An address, a write-data byte and a one-cycle write strobe go out. A one-cycle read strobe also goes out, and the register file must return the addressed byte on `reg_rdata` in that same cycle. Neither side has a valid/ready pair. The serial master cannot be stalled, so the register file must take every strobe, and no back-pressure path exists.

Top module: `spi_regslave`

## Requirements
- R1: While chip select is high, clock and data toggles cause no register strobe, and MISO is held at 0.
- R2: Serial mode: SCK idles high. MISO changes after a falling SCK edge and MOSI is sampled on a rising edge. Every byte is sent MSB first.
- R3: The command byte layout is: bit 7 = 1 for a read and 0 for a write, bits 6:2 = register address, bit 1 = burst-read flag, bit 0 reserved and ignored. For writes the burst flag has no effect.
- R4: During the command byte, MISO shifts out the 8-bit interrupt flag vector, MSB first, as captured while chip select was high.
- R5: Each complete write data byte produces exactly one single-cycle write strobe. It carries the command address and that byte. Further write bytes in the same transaction go to the same address.
- R6: A data byte cut short by chip select rising produces no write strobe and changes no register.
- R7: A read without the burst flag returns the register at the command address on every data byte. Each fetch is a single-cycle read strobe.
- R8: A burst read returns consecutive registers starting at the command address. The address increments after each byte and wraps from 31 to 0.
- R9: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles high |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| irq_flags | input | 8 | Interrupt flag vector returned as the status byte |
| reg_addr | output | 5 | Register address for both strobes |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid in the cycle of the read strobe |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_rd_en | output | 1 | Single-cycle read strobe |

## Verification
Every one of the 32 registers is written and read back. The bench sets the reserved and burst bits differently from address to address, so a decoder that mistook either bit for an address bit would land data in the wrong register. A burst read starts at address 29 and runs past the top of the space. A design that saturated at 31, or carried into a sixth address bit, would return the wrong bytes after the wrap. A transaction ends chip select in the middle of a data byte; a design that failed to clear its bit counter would leak a write strobe. The bench also drives several different flag patterns and checks that each comes back whole during the command byte; an off-by-one in the first MISO bit would shift every one of them.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = $clog2(DATA_W);

  typedef struct packed {
    logic              is_read;
    logic [ADDR_W-1:0] addr;
    logic              burst;
    logic              rsvd;
  } cmd_t;
endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  input  logic mosi,
  output logic csn_s,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE_VAL = 3'b110; // {sck, csn, mosi}

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sck_q;

  assign raw = {sck, csn, mosi};

  for (genvar i = 0; i < NSIG; i++) begin : g_chain
    logic [DEPTH-1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= {DEPTH{IDLE_VAL[i]}};
      else        stage <= {stage[DEPTH-2:0], raw[i]};
    end
    assign synced[i] = stage[DEPTH-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b1;
    else        sck_q <= synced[2];
  end

  assign csn_s    = synced[1];
  assign mosi_s   = synced[0];
  assign sck_rise = synced[2] & ~sck_q;
  assign sck_fall = ~synced[2] & sck_q;
endmodule

// File: rtl/spi_rs_shift.sv
module spi_rs_shift
  import spi_rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] status,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              miso
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else if (csn_s) begin
      bit_cnt   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sck_rise) begin
        rx_byte <= {rx_byte[DATA_W-2:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
      end
    end
  end

  // Status is tracked while deselected, so it is frozen as the select falls.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       tx_sr <= '0;
    else if (csn_s)                   tx_sr <= status;
    else if (load_en)                 tx_sr <= load_val;
    else if (byte_done)               tx_sr <= '0;
    else if (sck_fall && bit_cnt != 0) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
  end

  assign miso = csn_s ? 1'b0 : tx_sr[DATA_W-1];
endmodule

// File: rtl/spi_rs_ctrl.sv
module spi_rs_ctrl
  import spi_rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr_en,
  output logic              reg_rd_en
);
  cmd_t cmd_in;
  logic expect_cmd;
  logic rd_mode;
  logic burst_mode;

  assign cmd_in = cmd_t'(rx_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_cmd <= 1'b1;
      rd_mode    <= 1'b0;
      burst_mode <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      reg_wr_en  <= 1'b0;
      reg_rd_en  <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      reg_rd_en <= 1'b0;
      if (csn_s) begin
        expect_cmd <= 1'b1;
      end else if (byte_done) begin
        if (expect_cmd) begin
          expect_cmd <= 1'b0;
          rd_mode    <= cmd_in.is_read;
          burst_mode <= cmd_in.burst;
          reg_addr   <= cmd_in.addr;
          reg_rd_en  <= cmd_in.is_read;
        end else if (rd_mode) begin
          if (burst_mode) reg_addr <= reg_addr + 1'b1;
          reg_rd_en <= 1'b1;
        end else begin
          reg_wdata <= rx_byte;
          reg_wr_en <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_rs_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [DATA_W-1:0] irq_flags,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_wr_en,
  output logic              reg_rd_en
);
  logic              csn_s, mosi_s, sck_rise, sck_fall;
  logic              byte_done;
  logic [DATA_W-1:0] rx_byte;

  spi_rs_sync #(.DEPTH(SYNC_DEPTH)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
    .csn_s(csn_s), .mosi_s(mosi_s), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  spi_rs_shift shift_i (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .mosi_s(mosi_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .status(irq_flags),
    .load_en(reg_rd_en), .load_val(reg_rdata),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  spi_rs_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .byte_done(byte_done),
    .rx_byte(rx_byte), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en)
  );
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk (
  input logic clk,
  input logic rst_n,
  input logic csn_s,
  input logic miso,
  input logic wr_en,
  input logic rd_en
);
  assert_idle_no_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |-> $past(!csn_s));
  assert_idle_miso_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && $past(csn_s)) |-> !miso);
  assert_wr_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_rd_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
endmodule

bind spi_regslave spi_regslave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .miso(spi_miso),
  .wr_en(reg_wr_en), .rd_en(reg_rd_en)
);

// File: tb/spi_regslave_tb_top.sv
`timescale 1ns/1ps
module spi_regslave_tb_top;
  localparam int HALF = 5; // system clocks per serial half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csn = 1'b1, sck = 1'b1, mosi = 1'b0;
  logic       miso;
  logic [7:0] irq = 8'h00;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_wr_en, reg_rd_en;

  logic [7:0] mem [32];
  int total = 0, bad = 0, wr_cnt = 0, dbl_pulse = 0, both_cnt = 0, cyc = 0;
  logic wr_q = 1'b0;

  always #2.5 clk = ~clk;

  spi_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .irq_flags(irq), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_wr_en) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (reg_wr_en && wr_q) dbl_pulse <= dbl_pulse + 1;
    if (reg_wr_en && reg_rd_en) both_cnt <= both_cnt + 1;
    wr_q <= reg_wr_en;
  end

  function automatic logic [7:0] pat(int a, int k);
    return 8'((a * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      sck = 1'b0; mosi = tx[b];
      wait_clk(HALF);
      rx[b] = miso;
      sck = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic sel; csn = 1'b0; wait_clk(HALF); endtask
  task automatic desel; csn = 1'b1; wait_clk(4 * HALF); endtask

  function automatic logic [7:0] cmd(bit rd, int a, bit burst, bit rsvd);
    return {rd, 5'(a), burst, rsvd};
  endfunction

  initial begin
    logic [7:0] rx;
    logic [7:0] expv [32];
    int wbase;
    for (int a = 0; a < 32; a++) mem[a] = 8'h00;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    check(miso == 0 && !reg_wr_en && !reg_rd_en, "R1 reset outputs", miso, 0);

    // R1: toggles while deselected
    for (int i = 0; i < 16; i++) begin
      sck = i[0]; mosi = i[1];
      wait_clk(HALF);
      check(miso == 0, "R1 miso idle", miso, 0);
    end
    sck = 1'b1;
    wait_clk(4);
    check(wr_cnt == 0, "R1 no strobe while idle", wr_cnt, 0);

    // R3/R4/R5: write every register, flags vary, burst/reserved bits vary
    for (int a = 0; a < 32; a++) begin
      expv[a] = pat(a, 0);
      irq = 8'(a * 53 + 17);
      wait_clk(2);
      wbase = wr_cnt;
      sel();
      xfer(cmd(1'b0, a, a[0], a[1]), rx);
      check(rx == irq, "R4 status byte", rx, irq);
      xfer(expv[a], rx);
      desel();
      check(wr_cnt == wbase + 1, "R5 one strobe per byte", wr_cnt - wbase, 1);
    end
    for (int a = 0; a < 32; a++)
      check(mem[a] == expv[a], "R3 R5 write lands at decoded address", mem[a], expv[a]);

    // R5: multi-byte write stays at one address
    wbase = wr_cnt;
    sel();
    xfer(cmd(1'b0, 9, 1'b1, 1'b0), rx);
    for (int k = 1; k <= 3; k++) xfer(pat(9, k), rx);
    desel();
    expv[9] = pat(9, 3);
    check(wr_cnt == wbase + 3, "R5 three strobes", wr_cnt - wbase, 3);
    check(mem[9] == expv[9], "R5 last byte kept", mem[9], expv[9]);
    check(mem[10] == expv[10], "R5 neighbour untouched", mem[10], expv[10]);

    // R6: partial byte discarded
    wbase = wr_cnt;
    sel();
    xfer(cmd(1'b0, 3, 1'b0, 1'b0), rx);
    for (int b = 7; b >= 3; b--) begin
      sck = 1'b0; mosi = ~expv[3][b]; wait_clk(HALF);
      sck = 1'b1; wait_clk(HALF);
    end
    desel();
    check(wr_cnt == wbase, "R6 no strobe for partial byte", wr_cnt - wbase, 0);
    check(mem[3] == expv[3], "R6 register unchanged", mem[3], expv[3]);

    // R2/R7: single reads of every register
    for (int a = 0; a < 32; a++) begin
      sel();
      xfer(cmd(1'b1, a, 1'b0, a[2]), rx);
      xfer(8'h00, rx);
      desel();
      check(rx == expv[a], "R2 R7 single read", rx, expv[a]);
    end

    // R7: repeated bytes without burst
    sel();
    xfer(cmd(1'b1, 7, 1'b0, 1'b1), rx);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, rx);
      check(rx == expv[7], "R7 repeat same register", rx, expv[7]);
    end
    desel();

    // R8: burst across the wrap
    sel();
    xfer(cmd(1'b1, 29, 1'b1, 1'b0), rx);
    for (int k = 0; k < 6; k++) begin
      xfer(8'h00, rx);
      check(rx == expv[(29 + k) % 32], "R8 burst wrap", rx, expv[(29 + k) % 32]);
    end
    desel();

    check(dbl_pulse == 0, "R5 write strobe width", dbl_pulse, 0);
    check(both_cnt == 0, "R9 strobes exclusive", both_cnt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule